// File: doc/BRIEF.md
# Pause-Frame Flow-Control Trigger

This block watches how much of the receive buffer is still free and decides when the MAC has to ask its link partner to stop sending, and when it may let it resume. When free space drops under a high watermark, it requests a pause frame carrying the largest pause time (0xFFFF). Once that frame has gone out, it waits for free space to climb above a low watermark. It then requests a second pause frame with a zero pause time, which releases the partner. The gap between the two watermarks gives the hysteresis that stops the link from toggling on every small change in free space.

Both watermarks sit in one 8-bit read/write register, and each is counted in 1 KB units. The block has one request line and a 16-bit pause-time output, and it keeps the request high until a separate pause-frame generator signals that the frame has been sent. That generator builds the frame and its CRC. Only one request is outstanding at a time. A resume request is never raised before the matching stop frame has actually been transmitted.

Top module: `pause_flow_trigger`

## Requirements
- R1: After reset, the configuration register reads 0x38 (high watermark 3, low watermark 8), `pause_req` is 0 and `pause_time` is 0x0000.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the register, and `cfg_rdata` shows it from the next cycle on. Bits 7:4 hold the high watermark and bits 3:0 hold the low watermark, each in units of 1024 bytes.
- R3: When no request is pending and no stop frame has been sent, free space below high×1024 bytes on a clock edge raises `pause_req` after that edge with `pause_time` = 0xFFFF. Free space equal to or above that value raises nothing.
- R4: With a high watermark of 0, the stop request is raised only when `free_bytes` is 0.
- R5: A raised request stays high with an unchanged `pause_time` until a cycle in which `pause_done` is high. It drops after that edge.
- R6: After the stop frame is done, the resume request is raised only when free space is strictly greater than low×1024 bytes. Equal or lower free space raises nothing.
- R7: The resume request carries `pause_time` = 0x0000. Once it is done, the block is idle again, and a further stop request follows on the next edge if free space is still below the high watermark.
- R8: `pause_done` has no effect while `pause_req` is low.
- R9: While a stop frame has been sent and no resume frame has followed, low free space raises no second stop request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the watermark register |
| cfg_wdata | input | 8 | Write data: [7:4] high watermark, [3:0] low watermark, in KB |
| cfg_rdata | output | 8 | Current watermark register |
| free_bytes | input | FREE_W | Free receive-buffer space in bytes |
| pause_done | input | 1 | Pause-frame generator has sent the requested frame |
| pause_req | output | 1 | Request for a pause frame |
| pause_time | output | 16 | Pause time for the requested frame (0xFFFF stop, 0x0000 resume) |

## Verification
The stop trigger is swept over every high watermark, with free space at the threshold, one byte on either side of it, and at 0 and 1. This separates a strict comparison from an inclusive one and shows the special case of a zero watermark. The resume trigger is swept over every low watermark with free space exactly at the threshold and then one byte above it, which again tests for strictness. Each pass also holds the stop request without a done pulse and drives low free space while paused. It pulses done in phases where no request is pending, then checks that the block re-arms after the resume frame.

// File: rtl/pause_flow_trigger.sv
module pause_flow_trigger #(
  parameter int          FREE_W    = 15,
  parameter logic [7:0]  CFG_RESET = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [FREE_W-1:0] free_bytes,
  input  logic              pause_done,
  output logic              pause_req,
  output logic [15:0]       pause_time
);
  localparam int UNIT_SH = 10;

  typedef enum logic [1:0] {IDLE, XOFF_REQ, PAUSED, XON_REQ} state_t;
  state_t state, state_nx;

  logic [7:0] cfg;
  logic [FREE_W:0] hi_bytes, lo_bytes, free_x;
  logic hi_trip, lo_clear;

  assign free_x   = {1'b0, free_bytes};
  assign hi_bytes = {{(FREE_W-3){1'b0}}, cfg[7:4]} << UNIT_SH;
  assign lo_bytes = {{(FREE_W-3){1'b0}}, cfg[3:0]} << UNIT_SH;
  assign hi_trip  = (cfg[7:4] == 4'd0) ? (free_bytes == '0) : (free_x < hi_bytes);
  assign lo_clear = free_x > lo_bytes;

  always_comb begin
    state_nx = state;
    case (state)
      IDLE:     if (hi_trip)    state_nx = XOFF_REQ;
      XOFF_REQ: if (pause_done) state_nx = PAUSED;
      PAUSED:   if (lo_clear)   state_nx = XON_REQ;
      XON_REQ:  if (pause_done) state_nx = IDLE;
      default:                  state_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      cfg   <= CFG_RESET;
    end else begin
      state <= state_nx;
      if (cfg_we) cfg <= cfg_wdata;
    end
  end

  assign cfg_rdata  = cfg;
  assign pause_req  = (state == XOFF_REQ) || (state == XON_REQ);
  assign pause_time = (state == XOFF_REQ) ? 16'hFFFF : 16'h0000;
endmodule

// File: rtl/pause_flow_trigger_chk.sv
module pause_flow_trigger_chk #(
  parameter int FREE_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_rdata,
  input logic [FREE_W-1:0] free_bytes,
  input logic              pause_done,
  input logic              pause_req,
  input logic [15:0]       pause_time
);
  logic paused_c;
  logic trip_c, clear_c;
  int unsigned hi_b, lo_b;

  assign hi_b    = int'(cfg_rdata[7:4]) * 1024;
  assign lo_b    = int'(cfg_rdata[3:0]) * 1024;
  assign trip_c  = (cfg_rdata[7:4] == 4'd0) ? (free_bytes == '0) : (int'(free_bytes) < hi_b);
  assign clear_c = int'(free_bytes) > lo_b;

  always_ff @(posedge clk) begin
    if (!rst_n) paused_c <= 1'b0;
    else if (pause_req && pause_done) paused_c <= (pause_time == 16'hFFFF);
  end

  assert_time_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> (pause_time == 16'hFFFF || pause_time == 16'h0000));

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !pause_done) |=> (pause_req && $stable(pause_time)));

  assert_req_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && pause_done) |=> !pause_req);

  assert_xoff_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!paused_c && !pause_req && trip_c) |=> (pause_req && pause_time == 16'hFFFF));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!paused_c && !pause_req && !trip_c) |=> !pause_req);

  assert_xon_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_c && !pause_req && clear_c) |=> (pause_req && pause_time == 16'h0000));

  assert_no_second_xoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_c && !pause_req && !clear_c) |=> !pause_req);
endmodule

bind pause_flow_trigger pause_flow_trigger_chk #(.FREE_W(FREE_W)) chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .free_bytes(free_bytes),
  .pause_done(pause_done), .pause_req(pause_req), .pause_time(pause_time)
);

// File: tb/pause_flow_trigger_test.sv
module pause_flow_trigger_test;
  localparam int FREE_W = 15;
  localparam int FREE_MAX = (1 << FREE_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, pause_done = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic [FREE_W-1:0] free_bytes = '1;
  logic pause_req;
  logic [15:0] pause_time;
  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  pause_flow_trigger #(.FREE_W(FREE_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .free_bytes(free_bytes), .pause_done(pause_done),
    .pause_req(pause_req), .pause_time(pause_time));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; pause_done = 1'b0; free_bytes = FREE_W'(FREE_MAX);
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 cfg", int'(cfg_rdata), 'h38);
    chk("R1 req", int'(pause_req), 0);
    chk("R1 time", int'(pause_time), 0);
    free_bytes = FREE_W'(3072); tick();
    chk("R1 default hi at 3072", int'(pause_req), 0);
    free_bytes = FREE_W'(3071); tick();
    chk("R1 default hi at 3071", int'(pause_req), 1);

    for (int v = 0; v < 256; v += 17) begin
      do_reset();
      write_cfg(8'(v));
      chk("R2 readback", int'(cfg_rdata), v);
    end

    // R3/R4 sweep of the high watermark
    for (int hi = 0; hi < 16; hi++) begin
      int pts[5];
      pts[0] = 0; pts[1] = 1;
      pts[2] = (hi * 1024 > 0) ? hi * 1024 - 1 : 2;
      pts[3] = hi * 1024; pts[4] = hi * 1024 + 1;
      for (int p = 0; p < 5; p++) begin
        int exp;
        do_reset();
        write_cfg({4'(hi), 4'd15});
        pause_done = 1'b1; tick(); pause_done = 1'b0;
        chk("R8 done while idle", int'(pause_req), 0);
        free_bytes = FREE_W'(pts[p]);
        tick();
        exp = (hi == 0) ? int'(pts[p] == 0) : int'(pts[p] < hi * 1024);
        chk(hi == 0 ? "R4 zero watermark" : "R3 xoff trigger", int'(pause_req), exp);
        if (exp == 1) chk("R3 xoff time", int'(pause_time), 'hFFFF);
      end
    end

    // R5/R6/R7/R9 sweep of the low watermark
    for (int lo = 0; lo < 16; lo++) begin
      do_reset();
      write_cfg({4'd15, 4'(lo)});
      free_bytes = '0;
      tick();
      chk("R3 xoff raised", int'(pause_req), 1);
      tick(); tick();
      chk("R5 held req", int'(pause_req), 1);
      chk("R5 held time", int'(pause_time), 'hFFFF);
      pause_done = 1'b1; tick(); pause_done = 1'b0;
      chk("R5 drop after done", int'(pause_req), 0);
      tick();
      chk("R9 no second xoff", int'(pause_req), 0);
      free_bytes = FREE_W'(lo * 1024);
      pause_done = 1'b1; tick(); pause_done = 1'b0;
      chk("R8 done while paused", int'(pause_req), 0);
      tick();
      chk("R6 equal holds off", int'(pause_req), 0);
      free_bytes = FREE_W'(lo * 1024 + 1);
      tick();
      chk("R6 xon raised", int'(pause_req), 1);
      chk("R7 xon time", int'(pause_time), 0);
      tick();
      chk("R5 xon held", int'(pause_req), 1);
      pause_done = 1'b1; tick(); pause_done = 1'b0;
      chk("R7 idle after xon", int'(pause_req), 0);
      tick();
      chk("R7 re-arm", int'(pause_req), int'(lo < 15));
      if (lo < 15) chk("R7 re-arm time", int'(pause_time), 'hFFFF);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule